// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block is one 8-bit general-purpose I/O port that hangs off a simple CPU register bus. Four per-bit registers define each pin: the output value, the direction, the pull-up enable and the open-drain select. From these the block derives three pad-side vectors: an output value, an output enable and a pull-up enable. The level sampled on the pad comes back through a two-flop synchronizer.

A CPU read has two strobes. `bus_rd_reg` returns the stored contents of the addressed register. `bus_rd_pin`, when it is aimed at the data offset, returns the synchronized pin levels. This lets software tell the value it wrote apart from the level the pin really carries, for example on an open-drain line held low by another device.

Reads go through a three-state response machine. The states are `RD_IDLE` (no response), `RD_LATCH` (register read-back) and `RD_PIN` (pin read). In every cycle the next state follows the strobes of that cycle:
- `bus_rd_pin` high leads to `RD_PIN`.
- Otherwise `bus_rd_reg` high leads to `RD_LATCH`.
- Otherwise the next state is `RD_IDLE`.

The read address is latched together with the state. The response is therefore shown in the cycle after the strobe.

Top module: `gpio_port`

## Requirements
- R1: While reset is active and right after it, the data, direction, pull-up and open-drain registers are all 0. `pad_oe`, `pad_out` and `pad_pu` are all 0, and `bus_rvalid` is 0.
- R2: A write (`bus_wr` high at a clock edge) loads `bus_wdata` into one register. The register depends on the address, with n = `PORT_IDX`: data at 0xC0+n, direction at 0xC8+n, pull-up at 0xD0+n, open-drain at 0xD8+n.
- R3: A bit with direction 1 and open-drain 0 is a push-pull output. It has `pad_oe`=1, `pad_out` equal to its data bit, and `pad_pu`=0.
- R4: A bit with direction 0 is an input. It has `pad_oe`=0 and `pad_pu` equal to its pull-up bit. Its `pad_out` equals its data bit when open-drain is 0, and is 0 when open-drain is 1.
- R5: A bit with direction 1 and open-drain 1 is an open-drain output. It has `pad_out`=0 and `pad_oe` equal to the inverse of its data bit. Its `pad_pu` is the pull-up bit when the data bit is 1, and 0 when the data bit is 0.
- R6: A `bus_rd_reg` strobe to a mapped offset gives `bus_rvalid`=1 in the next cycle. `bus_rdata` then equals that register's contents in that cycle, which includes a write made at the strobe's own edge.
- R7: A `bus_rd_pin` strobe to the data offset gives, in the next cycle, `bus_rdata` equal to `pin_in` as sampled at the clock edge before the strobe's edge (two synchronizer stages).
- R8: When both read strobes are high, the pin read wins. A `bus_rd_pin` strobe to any mapped offset other than data returns that register's contents.
- R9: A write to an unmapped offset changes no register. A read from an unmapped offset gives `bus_rvalid`=1 with `bus_rdata`=0x00.
- R10: `bus_rvalid` is 1 only in the cycle after a read strobe. When `bus_rvalid` is 0, `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register offset for writes and reads |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd_reg | input | 1 | Read strobe, register read-back |
| bus_rd_pin | input | 1 | Read strobe, pin level at data offset |
| bus_rdata | output | 8 | Read response data |
| bus_rvalid | output | 1 | Read response valid |
| pin_in | input | 8 | Raw pad input levels |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad driver enable |
| pad_pu | output | 8 | Pad pull-up enable |

## Verification
The bench builds the port with `PORT_IDX` = 2. The mapped offsets are then 0xC2, 0xCA, 0xD2 and 0xDA. Offsets that are mapped for port 0, such as 0xC0 and 0xC8, fall into the unmapped range, so the bench can show that the decode really adds the index rather than matching only the base. With random traffic over mapped and unmapped offsets and random pin levels, every per-bit mix of direction, open-drain and data is reached, along with both strobes together and writes landing on the same edge as reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DATA = 8'hC0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 8'hC8;
    localparam logic [ADDR_W-1:0] OFS_PU   = 8'hD0;
    localparam logic [ADDR_W-1:0] OFS_OD   = 8'hD8;

    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_LATCH = 2'd1,
        RD_PIN   = 2'd2
    } rd_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DATA = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_PU   = 3'd3,
        SEL_OD   = 3'd4
    } reg_sel_e;

    function automatic reg_sel_e port_decode(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] idx);
        reg_sel_e s;
        s = SEL_NONE;
        if (a == OFS_DATA + idx) s = SEL_DATA;
        if (a == OFS_DIR  + idx) s = SEL_DIR;
        if (a == OFS_PU   + idx) s = SEL_PU;
        if (a == OFS_OD   + idx) s = SEL_OD;
        return s;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  data_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  pu_o,
    output logic [WIDTH-1:0]  od_o
);
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(PORT_IDX);

    reg_sel_e wsel;
    assign wsel = port_decode(addr_i, IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            dir_o  <= '0;
            pu_o   <= '0;
            od_o   <= '0;
        end else if (wr_i) begin
            unique case (wsel)
                SEL_DATA: data_o <= wdata_i;
                SEL_DIR:  dir_o  <= wdata_i;
                SEL_PU:   pu_o   <= wdata_i;
                SEL_OD:   od_o   <= wdata_i;
                default:  ;
            endcase
        end
    end

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wsel == SEL_NONE) |=> $stable({data_o, dir_o, pu_o, od_o}));

    // R2
    data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_DATA + IDX) |=> (data_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] pu_i,
    input  logic [WIDTH-1:0] od_i,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o,
    output logic [WIDTH-1:0] pad_pu_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            pad_out_o[b] = data_i[b] & ~od_i[b];
            if (!dir_i[b]) begin
                pad_oe_o[b] = 1'b0;
                pad_pu_o[b] = pu_i[b];
            end else if (od_i[b]) begin
                pad_oe_o[b] = ~data_i[b];
                pad_pu_o[b] = pu_i[b] & data_i[b];
            end else begin
                pad_oe_o[b] = 1'b1;
                pad_pu_o[b] = 1'b0;
            end
        end
    end

    // R4
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~dir_i & pad_oe_o) == '0));

    // R5
    od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((od_i & pad_oe_o & pad_out_o) == '0));

    // R3
    pp_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_i & ~od_i & pad_pu_o) == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int PORT_IDX = 0,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    input  logic             bus_rd_reg,
    input  logic             bus_rd_pin,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             bus_rvalid,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(PORT_IDX);

    logic [WIDTH-1:0] data_q, dir_q, pu_q, od_q, pin_sync;
    rd_state_e        st_q, st_d;
    reg_sel_e         sel_q, sel_d;

    gpio_regs #(.WIDTH(WIDTH), .PORT_IDX(PORT_IDX)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_wr),
        .addr_i (bus_addr),
        .wdata_i(bus_wdata),
        .data_o (data_q),
        .dir_o  (dir_q),
        .pu_o   (pu_q),
        .od_o   (od_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (pin_sync)
    );

    gpio_pad #(.WIDTH(WIDTH)) u_pad (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (data_q),
        .dir_i    (dir_q),
        .pu_i     (pu_q),
        .od_i     (od_q),
        .pad_out_o(pad_out),
        .pad_oe_o (pad_oe),
        .pad_pu_o (pad_pu)
    );

    always_comb begin
        sel_d = port_decode(bus_addr, IDX);
        if (bus_rd_pin)      st_d = RD_PIN;
        else if (bus_rd_reg) st_d = RD_LATCH;
        else                 st_d = RD_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= RD_IDLE;
            sel_q <= SEL_NONE;
        end else begin
            st_q  <= st_d;
            sel_q <= sel_d;
        end
    end

    function automatic logic [WIDTH-1:0] reg_view(input reg_sel_e s);
        unique case (s)
            SEL_DATA: return data_q;
            SEL_DIR:  return dir_q;
            SEL_PU:   return pu_q;
            SEL_OD:   return od_q;
            default:  return '0;
        endcase
    endfunction

    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (st_q)
            RD_IDLE: ;
            RD_LATCH: begin
                bus_rvalid = 1'b1;
                bus_rdata  = reg_view(sel_q);
            end
            RD_PIN: begin
                bus_rvalid = 1'b1;
                bus_rdata  = (sel_q == SEL_DATA) ? pin_sync : reg_view(sel_q);
            end
            default: ;
        endcase
    end

    // R10
    rvalid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd_reg || bus_rd_pin));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

    // R8
    pin_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_pin && bus_rd_reg) |=> (st_q == RD_PIN));

    // R9
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd_reg || bus_rd_pin) && port_decode(bus_addr, IDX) == SEL_NONE)
        |=> (bus_rvalid && bus_rdata == '0));
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int CLK_PERIOD = 10;
    localparam int IDX = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       bus_rd_reg = 1'b0;
    logic       bus_rd_pin = 1'b0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;

    gpio_port #(.PORT_IDX(IDX)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd_reg(bus_rd_reg), .bus_rd_pin(bus_rd_pin),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    // Reference model: register contents, pin history and pending read.
    logic [7:0] m_reg [4];
    logic [7:0] m_pins [$] = '{8'h00, 8'h00};
    int         m_kind = 0;   // 0 none, 1 register read, 2 pin read
    int         m_which = -1; // -1 unmapped, else 0 data 1 dir 2 pu 3 od
    bit         m_both = 0;

    function automatic int which_reg(input logic [7:0] a);
        for (int k = 0; k < 4; k++)
            if (a == 8'(8'hC0 + 8 * k + IDX)) return k;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
            m_pins = '{8'h00, 8'h00};
            m_kind = 0; m_which = -1; m_both = 0;
        end else begin
            m_pins.push_back(pin_in);
            void'(m_pins.pop_front());
            if (bus_wr && which_reg(bus_addr) >= 0) m_reg[which_reg(bus_addr)] = bus_wdata;
            m_kind  = bus_rd_pin ? 2 : (bus_rd_reg ? 1 : 0);
            m_which = which_reg(bus_addr);
            m_both  = bus_rd_pin && bus_rd_reg;
        end
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input bit in_reset);
        logic [7:0] e_out, e_oe, e_pu, e_rd;
        bit e_v;
        string tag;
        for (int b = 0; b < 8; b++) begin
            bit d, r, p, o;
            d = m_reg[0][b]; r = m_reg[1][b]; p = m_reg[2][b]; o = m_reg[3][b];
            e_out[b] = o ? 1'b0 : d;
            if (!r)     begin e_oe[b] = 1'b0; e_pu[b] = p; end
            else if (o) begin e_oe[b] = ~d;   e_pu[b] = d ? p : 1'b0; end
            else        begin e_oe[b] = 1'b1; e_pu[b] = 1'b0; end
        end
        tag = in_reset ? "R1 pads" : "R3/R4/R5 pads";
        check8({tag, " out"}, pad_out, e_out);
        check8({tag, " oe"}, pad_oe, e_oe);
        check8({tag, " pu"}, pad_pu, e_pu);
        e_v = (m_kind != 0);
        if (m_kind == 0)          begin e_rd = 8'h00; tag = in_reset ? "R1 rdata" : "R10 rdata"; end
        else if (m_which < 0)     begin e_rd = 8'h00; tag = "R9 rdata"; end
        else if (m_kind == 2 && m_which == 0) begin e_rd = m_pins[0]; tag = m_both ? "R8 rdata" : "R7 rdata"; end
        else begin e_rd = m_reg[m_which]; tag = m_both ? "R8 rdata" : "R2/R6 rdata"; end
        check8(tag, bus_rdata, e_rd);
        check8(in_reset ? "R1 rvalid" : "R10 rvalid", {7'd0, bus_rvalid}, {7'd0, e_v});
    endtask

    task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                        input bit rr, input bit rp);
        bus_wr = wr; bus_addr = a; bus_wdata = wd; bus_rd_reg = rr; bus_rd_pin = rp;
        pin_in = 8'($urandom);
        @(negedge clk);
        compare_all(!rst_n);
    endtask

    localparam logic [7:0] A_DATA = 8'(8'hC0 + IDX);
    localparam logic [7:0] A_DIR  = 8'(8'hC8 + IDX);
    localparam logic [7:0] A_PU   = 8'(8'hD0 + IDX);
    localparam logic [7:0] A_OD   = 8'(8'hD8 + IDX);

    initial begin
        @(negedge clk);
        compare_all(1);  // R1 during reset
        @(negedge clk);
        compare_all(1);
        rst_n = 1'b1;
        step(0, 8'h00, 8'h00, 0, 0);                   // R1 right after reset
        step(1, A_DIR, 8'h55, 0, 0);                   // R2 even outputs
        step(1, A_DATA, 8'hF0, 1, 0);                  // R6 read with same-edge write
        step(1, A_PU, 8'hFF, 1, 0);
        step(1, A_OD, 8'h0F, 1, 0);                    // R5 open-drain low nibble
        step(0, A_DIR, 8'h00, 1, 0);                   // R6
        step(0, A_DATA, 8'h00, 0, 1);                  // R7
        step(0, A_DATA, 8'h00, 1, 1);                  // R8 both strobes
        step(0, A_PU, 8'h00, 0, 1);                    // R8 pin read of non-data
        step(1, 8'hC0, 8'hAA, 0, 0);                   // R9 unmapped for IDX 2
        step(1, 8'hC8, 8'hAA, 1, 0);                   // R9
        step(0, A_DATA, 8'h00, 1, 0);
        step(0, A_DIR, 8'h00, 0, 0);                   // R10 idle
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            int pick;
            pick = $urandom_range(0, 5);
            case (pick)
                0: a = A_DATA; 1: a = A_DIR; 2: a = A_PU; 3: a = A_OD;
                4: a = 8'hC0;  default: a = 8'($urandom);
            endcase
            step(1'($urandom), a, 8'($urandom), 1'($urandom), 1'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule